// File: doc/BRIEF.md
# Code Fetch Execution Gate

The gate sits between a host's direct read port and the memory read path. Every host request carries a byte address and a 4-bit multi-bit-boolean tag that marks it as either a data read or an instruction fetch. Data reads always pass. An instruction fetch passes only when software has written a 32-bit unlock key that equals a constant fixed at build time. A request whose tag is neither valid encoding is answered with a bus error.

The memory read is issued for every accepted request, whatever the verdict. When the verdict is deny or error, the gate forces the returned word to zero and raises the error flag. Each accepted request gets exactly one response cycle. The gate holds at most one request in flight, so it accepts at most one request every two cycles.

Top module: `code_fetch_gate`

## Requirements
- R1: After reset the unlock key register holds 0, `rsp_valid` is low and `req_ready` is high. An instruction fetch issued before any key write is therefore denied.
- R2: A request with tag 4'h9 (data read) returns the memory word with `rsp_err` low. This holds for any key value.
- R3: A request with tag 4'h6 (instruction fetch) returns the memory word with `rsp_err` low when the key register equals parameter `EXEC_KEY`, whose default is 32'hA26A38F7.
- R4: An instruction fetch while the key does not equal `EXEC_KEY` returns `rsp_data` = 0 with `rsp_err` high.
- R5: A request with any tag other than 4'h6 or 4'h9 returns `rsp_data` = 0 with `rsp_err` high, for any key value.
- R6: Every accepted request, including a denied one or one with an invalid tag, pulses `mem_req` for one cycle. The pulse carries the word index `mem_addr` = `req_addr[AW-1:2]`. The memory answers on `mem_rdata` one cycle later.
- R7: A request is accepted in a cycle where `req_valid` and `req_ready` are both high. `rsp_valid` is high for exactly the one cycle after acceptance, and `req_ready` is low during that cycle.
- R8: When a key write (`key_we`) and a request acceptance fall in the same cycle, the verdict uses the key as it stood before the write. The new key governs requests accepted from the next cycle onward.
- R9: All 32 bits of the key take part in the comparison: a key that differs from `EXEC_KEY` in any single bit denies a fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_we | input | 1 | Software write strobe for the unlock key |
| key_wdata | input | 32 | Key value to write |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Gate can accept a request |
| req_addr | input | AW | Byte address of the requested word |
| req_itype | input | 4 | Multi-bit tag: 4'h9 data, 4'h6 fetch, other values invalid |
| mem_req | output | 1 | Memory read strobe |
| mem_addr | output | AW-2 | Memory word index |
| mem_rdata | input | 32 | Memory word, valid one cycle after `mem_req` |
| rsp_valid | output | 1 | Response pulse |
| rsp_data | output | 32 | Returned word, or zero when denied or in error |
| rsp_err | output | 1 | Bus error response |

## Verification
A software key write and a host request acceptance can fall in the same clock edge. The bench provokes this by raising `key_we` and `req_valid` in the same half-cycle, in both directions:
- The matching key is written while a fetch is accepted. The bench expects that fetch to be denied and the next fetch to pass.
- The key is cleared while a fetch is accepted. The bench expects that fetch to pass and the next fetch to be denied.

Around this, the bench sweeps all sixteen tag values against a zero key, the matching key, an all-ones key and every single-bit corruption of the matching key. It checks data, error flag, handshake and the memory strobe of each request against values it computes itself.

// File: rtl/fcg_pkg.sv
package fcg_pkg;

    localparam logic [3:0] MUBI_TRUE  = 4'h6;
    localparam logic [3:0] MUBI_FALSE = 4'h9;

    typedef enum logic [1:0] {
        ACC_DATA  = 2'd0,
        ACC_FETCH = 2'd1,
        ACC_BAD   = 2'd2
    } acc_kind_e;

    typedef struct packed {
        logic pend;
        logic allow;
    } fcg_state_t;

    function automatic acc_kind_e decode_tag(input logic [3:0] tag);
        if (tag == MUBI_FALSE) begin
            return ACC_DATA;
        end else if (tag == MUBI_TRUE) begin
            return ACC_FETCH;
        end
        return ACC_BAD;
    endfunction

endpackage

// File: rtl/fcg_key_reg.sv
module fcg_key_reg #(
    parameter int KW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [KW-1:0] wdata,
    output logic [KW-1:0] key
);
    logic [KW-1:0] key_d, key_q;

    always_comb begin
        key_d = key_q;
        if (we) begin
            key_d = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q <= '0;
        end else begin
            key_q <= key_d;
        end
    end

    assign key = key_q;
endmodule

// File: rtl/fcg_classify.sv
module fcg_classify
    import fcg_pkg::*;
#(
    parameter int          KW       = 32,
    parameter logic [KW-1:0] EXEC_KEY = 32'hA26A38F7
) (
    input  logic [3:0]    itype,
    input  logic [KW-1:0] key,
    output logic          allow
);
    acc_kind_e kind;
    logic      key_match;

    assign kind      = decode_tag(itype);
    assign key_match = (key == EXEC_KEY);

    always_comb begin
        unique case (kind)
            ACC_DATA:  allow = 1'b1;
            ACC_FETCH: allow = key_match;
            default:   allow = 1'b0;
        endcase
    end
endmodule

// File: rtl/code_fetch_gate.sv
module code_fetch_gate
    import fcg_pkg::*;
#(
    parameter int          AW       = 12,
    parameter int          KW       = 32,
    parameter int          DW       = 32,
    parameter logic [KW-1:0] EXEC_KEY = 32'hA26A38F7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          key_we,
    input  logic [KW-1:0] key_wdata,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [3:0]    req_itype,
    output logic          mem_req,
    output logic [AW-3:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          rsp_err
);
    logic [KW-1:0] key;
    logic          cls_allow;
    logic          accept;
    logic          unused_lsb;
    fcg_state_t    st_d, st_q;

    fcg_key_reg #(.KW(KW)) u_key (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (key_we),
        .wdata (key_wdata),
        .key   (key)
    );

    fcg_classify #(.KW(KW), .EXEC_KEY(EXEC_KEY)) u_cls (
        .itype (req_itype),
        .key   (key),
        .allow (cls_allow)
    );

    assign accept     = req_valid && req_ready;
    assign unused_lsb = ^req_addr[1:0];

    always_comb begin
        st_d      = st_q;
        st_d.pend = accept;
        if (accept) begin
            st_d.allow = cls_allow;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = !st_q.pend;
    assign mem_req   = accept;
    assign mem_addr  = req_addr[AW-1:2];
    assign rsp_valid = st_q.pend;
    assign rsp_err   = st_q.pend && !st_q.allow;
    assign rsp_data  = (st_q.pend && st_q.allow) ? mem_rdata : '0;
endmodule

// File: rtl/fcg_gate_chk.sv
module fcg_gate_chk #(
    parameter int AW = 12,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [3:0]    req_itype,
    input logic [DW-1:0] mem_rdata,
    input logic          rsp_valid,
    input logic [DW-1:0] rsp_data,
    input logic          rsp_err
);
    logic acc;
    assign acc = req_valid && req_ready;

    assert_rsp_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid);

    assert_rsp_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_ready_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> req_ready);

    assert_err_zero_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_data == '0));

    assert_data_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_itype == 4'h9) |=> (rsp_valid && !rsp_err && rsp_data == mem_rdata));

    assert_bad_tag_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_itype != 4'h9 && req_itype != 4'h6) |=> rsp_err);
endmodule

bind code_fetch_gate fcg_gate_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_itype (req_itype),
    .mem_rdata (mem_rdata),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_err   (rsp_err)
);

// File: tb/tb_code_fetch_gate.sv
module tb_code_fetch_gate;
    localparam int          AW  = 12;
    localparam logic [31:0] KEY = 32'hA26A38F7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          key_we = 1'b0;
    logic [31:0]   key_wdata = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [3:0]    req_itype = 4'h9;
    logic          mem_req;
    logic [AW-3:0] mem_addr;
    logic [31:0]   mem_rdata = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_data;
    logic          rsp_err;

    int n_chk = 0;
    int n_err = 0;
    int n_mem = 0;
    logic [AW-3:0] last_idx = '0;
    logic [31:0]   cur_key = '0;

    always #10 clk = ~clk;

    code_fetch_gate dut (
        .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_wdata(key_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_itype(req_itype), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_err(rsp_err)
    );

    function automatic logic [31:0] pat(input logic [AW-3:0] i);
        return 32'hC0DE0000 ^ ({{(34-AW){1'b0}}, i} * 32'h9E3779B1);
    endfunction

    always_ff @(posedge clk) begin
        if (mem_req) begin
            mem_rdata <= pat(mem_addr);
            last_idx  <= mem_addr;
            n_mem     <= n_mem + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_key(input logic [31:0] k);
        @(negedge clk);
        key_we = 1'b1;
        key_wdata = k;
        @(negedge clk);
        key_we = 1'b0;
        cur_key = k;
    endtask

    // exp_allow given explicitly; optional simultaneous key write
    task automatic do_req(input logic [AW-1:0] a, input logic [3:0] t, input bit exp_allow,
                          input bit wr, input logic [31:0] wk, input string tag);
        int n0;
        logic [31:0] ed;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr = a;
        req_itype = t;
        key_we = wr;
        key_wdata = wk;
        n0 = n_mem;
        chk({tag, " R7 ready"}, {31'd0, req_ready}, 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        key_we = 1'b0;
        if (wr) cur_key = wk;
        ed = exp_allow ? pat(a[AW-1:2]) : 32'd0;
        chk({tag, " R7 rsp_valid"}, {31'd0, rsp_valid}, 32'd1);
        chk({tag, " R7 busy"}, {31'd0, req_ready}, 32'd0);
        chk({tag, " err"}, {31'd0, rsp_err}, {31'd0, !exp_allow});
        chk({tag, " data"}, rsp_data, ed);
        chk({tag, " R6 mem strobe"}, n_mem, n0 + 1);
        chk({tag, " R6 mem index"}, {{(34-AW){1'b0}}, last_idx}, {{(34-AW){1'b0}}, a[AW-1:2]});
        @(negedge clk);
        chk({tag, " R7 single pulse"}, {31'd0, rsp_valid}, 32'd0);
    endtask

    function automatic bit model(input logic [3:0] t, input logic [31:0] k);
        return (t == 4'h9) || (t == 4'h6 && k == KEY);
    endfunction

    function automatic string tag_of(input logic [3:0] t);
        if (t == 4'h9) return "R2";
        if (t == 4'h6) return "R3/R4";
        return "R5";
    endfunction

    initial begin : wdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin : main
        logic [31:0] keys [3];
        repeat (3) @(negedge clk);
        chk("R1 rsp_valid reset", {31'd0, rsp_valid}, 32'd0);
        chk("R1 ready reset", {31'd0, req_ready}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rsp_valid idle", {31'd0, rsp_valid}, 32'd0);
        do_req(12'h010, 4'h6, 1'b0, 1'b0, '0, "R1 fetch after reset");

        keys[0] = 32'd0;
        keys[1] = KEY;
        keys[2] = 32'hFFFFFFFF;
        for (int k = 0; k < 3; k++) begin
            set_key(keys[k]);
            for (int t = 0; t < 16; t++) begin
                do_req(AW'((k * 16 + t) * 4 + 4), 4'(t), model(4'(t), keys[k]), 1'b0, '0,
                       tag_of(4'(t)));
            end
        end

        for (int b = 0; b < 32; b++) begin
            set_key(KEY ^ (32'd1 << b));
            do_req(AW'(b * 8), 4'h6, 1'b0, 1'b0, '0, "R9 bit flip fetch");
            do_req(AW'(b * 8 + 4), 4'h9, 1'b1, 1'b0, '0, "R2 bit flip data");
        end

        set_key(32'd0);
        do_req(12'hFFC, 4'h6, 1'b0, 1'b1, KEY, "R8 write key with fetch");
        do_req(12'h000, 4'h6, 1'b1, 1'b0, '0, "R8 fetch after write");
        do_req(12'h100, 4'h6, 1'b1, 1'b1, 32'd0, "R8 clear key with fetch");
        do_req(12'h104, 4'h6, 1'b0, 1'b0, '0, "R8 fetch after clear");
        do_req(12'h108, 4'h9, 1'b1, 1'b0, '0, "R2 data with zero key");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule